// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small CPU core and turns two interrupt sources into one request line. One source is a one-cycle request pulse from an on-chip timer. The other is an asynchronous external pin, which is synchronized and then watched for an edge of programmable polarity. Each source has its own enable bit in a control register. Every request that a source enable lets through is then held behind a single master enable bit in a status register.

When both sources are enabled and pending, the timer wins. The CPU sequencer answers the request with a one-cycle acknowledge and presents its current program counter. The block then captures the winner's fixed vector address and copies the program counter into a single return register. It also clears the master enable, so nested interrupts stay blocked until software sets that bit again. The two source enables are not touched. The timer request is held while its enable is off. An external request exists only while its enable is on.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `vec`, `ret_pc`, `ctl_q` and `sts_q` are all 0.
- R2: `irq` is 1 only when status bit 4 (the master enable) is 1 and at least one source is both pending and enabled. A request that arrives while bit 4 is 0 is held, and `irq` rises once bit 4 is set. A raised request stays raised until it is acknowledged or the register contents change.
- R3: A `tmr_req` pulse that arrives while control bit 1 (timer enable) is 0 is held. It raises `irq` once bit 1 is later set to 1.
- R4: An external request is created only by an active edge of `ext_pin` seen while control bit 0 (external enable) is 1. Control bit 2 selects the active edge: 1 for rising, 0 for falling. Edges seen while bit 0 is 0 are discarded. Because of the two-flop synchronizer, `irq` rises on the third rising clock edge after the pin changes.
- R5: If control bit 0 is cleared while an external request is pending, that request is cancelled, and setting the bit again does not bring it back.
- R6: An acknowledge while `irq` is 1 clears status bit 4 and leaves `ctl_q` unchanged. An acknowledge while `irq` is 0 changes no register.
- R7: When both sources are enabled and pending, the timer wins. On an accepted acknowledge, `vec` becomes 0x020 for a timer win and 0x0A0 for an external win.
- R8: On an accepted acknowledge, `ret_pc` takes the value of `pc_in`.
- R9: An acknowledge clears only the winner's pending request. The losing request stays pending and raises `irq` once status bit 4 is set again.
- R10: If a new request from a source arrives in the same cycle that acknowledges that source, the new request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_req | input | 1 | One-cycle timer request pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 0 external enable, bit 1 timer enable, bit 2 rising-edge select |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status write data; bit 4 is the master enable |
| ack | input | 1 | One-cycle acknowledge from the CPU sequencer |
| pc_in | input | PC_W | Current program counter |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | PC_W | Vector address captured at the last accepted acknowledge |
| ret_pc | output | PC_W | Return register, the program counter saved at the last accepted acknowledge |
| ctl_q | output | 8 | Control register contents |
| sts_q | output | 8 | Status register contents |

## Verification
The properties assume that `ack` is a single-cycle strobe. They do not assume that `ack` is sent only while `irq` is high, so the stimulus deliberately sends stray acknowledges to exercise the case where one is ignored. The hold-while-raised property only makes a claim in cycles with no register write and no acknowledge. The stimulus therefore mixes quiet stretches with writes that land on pending requests. The external pin is driven between clock edges, as a real asynchronous pin would be. The random phase toggles it freely under both edge polarities, while the timer pulses and acknowledges can land in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W         = 8;
    localparam int CTL_EXT_EN    = 0;
    localparam int CTL_TMR_EN    = 1;
    localparam int CTL_EDGE_RISE = 2;
    localparam int STS_IEN       = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

    typedef struct packed {
        logic tmr;
        logic ext;
    } req_t;

    // fixed priority: timer before external
    function automatic src_e pick_src(req_t act);
        if (act.tmr)      return SRC_TMR;
        else if (act.ext) return SRC_EXT;
        else              return SRC_NONE;
    endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sh;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= pin;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh[i] <= 1'b0;
            else     sh[i] <= sh[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= sh[TOP];
    end

    always_comb begin
        if (rise_sel) edge_hit = sh[TOP] & ~last;
        else          edge_hit = ~sh[TOP] & last;
    end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tmr_pulse,
    input  logic ext_edge,
    input  logic ext_en,
    input  req_t clr,
    output req_t pend
);
    req_t pend_n;

    always_comb begin
        // new arrivals win over the acknowledge clear
        pend_n.tmr = tmr_pulse | (pend.tmr & ~clr.tmr);
        // external request only lives while its enable is set
        pend_n.ext = ext_en & (ext_edge | (pend.ext & ~clr.ext));
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_n;
    end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter logic [PC_W-1:0] TMR_VEC = 12'h020,
    parameter logic [PC_W-1:0] EXT_VEC = 12'h0A0
) (
    input  req_t            pend,
    input  logic            tmr_en,
    input  logic            ext_en,
    input  logic            ien,
    output logic            irq,
    output src_e            win,
    output logic [PC_W-1:0] win_vec
);
    req_t act;

    always_comb begin
        act.tmr = pend.tmr & tmr_en;
        act.ext = pend.ext & ext_en;
        win     = pick_src(act);
        irq     = ien & (win != SRC_NONE);
        case (win)
            SRC_TMR: win_vec = TMR_VEC;
            SRC_EXT: win_vec = EXT_VEC;
            default: win_vec = '0;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int              PC_W        = 12,
    parameter int              SYNC_STAGES = 2,
    parameter logic [PC_W-1:0] TMR_VEC     = 12'h020,
    parameter logic [PC_W-1:0] EXT_VEC     = 12'h0A0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             tmr_req,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             sts_we,
    input  logic [REG_W-1:0] sts_wdata,
    input  logic             ack,
    input  logic [PC_W-1:0]  pc_in,
    output logic             irq,
    output logic [PC_W-1:0]  vec,
    output logic [PC_W-1:0]  ret_pc,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] sts_q
);
    logic            ext_edge;
    req_t            pend;
    req_t            clr;
    src_e            win;
    logic [PC_W-1:0] win_vec;
    logic            ack_ok;

    irqc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .rise_sel (ctl_q[CTL_EDGE_RISE]),
        .edge_hit (ext_edge)
    );

    irqc_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .tmr_pulse (tmr_req),
        .ext_edge  (ext_edge),
        .ext_en    (ctl_q[CTL_EXT_EN]),
        .clr       (clr),
        .pend      (pend)
    );

    irqc_arb #(.PC_W(PC_W), .TMR_VEC(TMR_VEC), .EXT_VEC(EXT_VEC)) u_arb (
        .pend    (pend),
        .tmr_en  (ctl_q[CTL_TMR_EN]),
        .ext_en  (ctl_q[CTL_EXT_EN]),
        .ien     (sts_q[STS_IEN]),
        .irq     (irq),
        .win     (win),
        .win_vec (win_vec)
    );

    always_comb begin
        ack_ok  = ack & irq;
        clr.tmr = ack_ok & (win == SRC_TMR);
        clr.ext = ack_ok & (win == SRC_EXT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            sts_q  <= '0;
            vec    <= '0;
            ret_pc <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_wdata;
            if (sts_we) sts_q <= sts_wdata;
            if (ack_ok) begin
                sts_q[STS_IEN] <= 1'b0;
                vec            <= win_vec;
                ret_pc         <= pc_in;
            end
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int              PC_W    = 12,
    parameter logic [PC_W-1:0] TMR_VEC = 12'h020,
    parameter logic [PC_W-1:0] EXT_VEC = 12'h0A0
) (
    input logic            clk,
    input logic            rst,
    input logic            ack,
    input logic [PC_W-1:0] pc_in,
    input logic            ctl_we,
    input logic            sts_we,
    input logic            irq,
    input logic [PC_W-1:0] vec,
    input logic [PC_W-1:0] ret_pc,
    input logic [7:0]      ctl_q,
    input logic [7:0]      sts_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_q == 8'h00 && sts_q == 8'h00 && !irq && vec == '0 && ret_pc == '0));

    // R2
    master_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !sts_q[4] |-> !irq);

    // R2
    hold_raised_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack && !ctl_we && !sts_we) |=> irq);

    // R6
    ack_clears_ien_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> !sts_q[4]);

    // R6
    ack_keeps_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq && !ctl_we) |=> $stable(ctl_q));

    // R6
    stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq && !sts_we) |=> ($stable(sts_q) && $stable(ret_pc) && $stable(vec)));

    // R7
    vec_value_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> (vec == TMR_VEC || vec == EXT_VEC));

    // R8
    ret_save_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> (ret_pc == $past(pc_in)));
endmodule

bind prio_irq_ctrl irqc_chk #(.PC_W(PC_W), .TMR_VEC(TMR_VEC), .EXT_VEC(EXT_VEC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ack    (ack),
    .pc_in  (pc_in),
    .ctl_we (ctl_we),
    .sts_we (sts_we),
    .irq    (irq),
    .vec    (vec),
    .ret_pc (ret_pc),
    .ctl_q  (ctl_q),
    .sts_q  (sts_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int PC_W = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ext_pin = 1'b0;
    logic            tmr_req = 1'b0;
    logic            ctl_we = 1'b0;
    logic [7:0]      ctl_wdata = 8'h00;
    logic            sts_we = 1'b0;
    logic [7:0]      sts_wdata = 8'h00;
    logic            ack = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic            irq;
    logic [PC_W-1:0] vec;
    logic [PC_W-1:0] ret_pc;
    logic [7:0]      ctl_q;
    logic [7:0]      sts_q;

    always #4 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_req(tmr_req),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
        .ack(ack), .pc_in(pc_in), .irq(irq), .vec(vec), .ret_pc(ret_pc),
        .ctl_q(ctl_q), .sts_q(sts_q)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0]      m_ctl, m_sts;
    bit              m_tp, m_ep;
    logic [PC_W-1:0] m_vec, m_ret;
    bit              mp1, mp2, mp3;

    function automatic bit m_irq();
        return m_sts[4] && ((m_tp && m_ctl[1]) || (m_ep && m_ctl[0]));
    endfunction

    task automatic m_reset();
        m_ctl = 0; m_sts = 0; m_tp = 0; m_ep = 0;
        m_vec = 0; m_ret = 0; mp1 = 0; mp2 = 0; mp3 = 0;
    endtask

    task automatic m_step();
        bit hit, t_act, e_act, req, win_t, acc, n_tp, n_ep;
        hit   = m_ctl[2] ? (mp2 && !mp3) : (!mp2 && mp3);
        t_act = m_tp && m_ctl[1];
        e_act = m_ep && m_ctl[0];
        req   = m_sts[4] && (t_act || e_act);
        win_t = t_act;
        acc   = ack && req;
        n_tp  = tmr_req || (m_tp && !(acc && win_t));
        n_ep  = m_ctl[0] && (hit || (m_ep && !(acc && !win_t)));
        if (acc) begin
            m_vec = win_t ? 12'h020 : 12'h0A0;
            m_ret = pc_in;
        end
        if (sts_we) m_sts = sts_wdata;
        if (acc) m_sts[4] = 1'b0;
        if (ctl_we) m_ctl = ctl_wdata;
        m_tp = n_tp; m_ep = n_ep;
        mp3 = mp2; mp2 = mp1; mp1 = ext_pin;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2", "model irq", 32'(irq), 32'(m_irq()));
        chk("R7", "model vec", 32'(vec), 32'(m_vec));
        chk("R8", "model ret_pc", 32'(ret_pc), 32'(m_ret));
        chk("R6", "model sts_q", 32'(sts_q), 32'(m_sts));
        chk("R6", "model ctl_q", 32'(ctl_q), 32'(m_ctl));
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) m_reset(); else m_step();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
    endtask

    task automatic wr_sts(logic [7:0] v);
        sts_we = 1; sts_wdata = v; tick(); sts_we = 0;
    endtask

    task automatic pulse_tmr();
        tmr_req = 1; tick(); tmr_req = 0;
    endtask

    task automatic do_ack(logic [PC_W-1:0] pc);
        ack = 1; pc_in = pc; tick(); ack = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        ticks(3);
        rst = 0;
        // R1 reset state
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "vec", 32'(vec), 0);
        chk("R1", "ret_pc", 32'(ret_pc), 0);
        chk("R1", "ctl_q", 32'(ctl_q), 0);
        chk("R1", "sts_q", 32'(sts_q), 0);

        // R3: timer held while its enable is off
        pulse_tmr();
        ticks(2);
        chk("R3", "irq timer disabled", 32'(irq), 0);
        wr_ctl(8'h02);
        chk("R2", "irq master off", 32'(irq), 0);
        wr_sts(8'h10);
        chk("R3", "irq after enables", 32'(irq), 1);
        do_ack(12'h123);
        chk("R7", "timer vec", 32'(vec), 32'h020);
        chk("R8", "ret_pc saved", 32'(ret_pc), 32'h123);
        chk("R6", "ien cleared", 32'(sts_q[4]), 0);
        chk("R6", "ctl kept", 32'(ctl_q), 32'h02);
        chk("R6", "irq low after ack", 32'(irq), 0);

        // R4: rising edge, three-edge latency
        wr_ctl(8'h05);
        wr_sts(8'h10);
        ext_pin = 1;
        ticks(2);
        chk("R4", "irq before sync", 32'(irq), 0);
        tick();
        chk("R4", "irq rising edge", 32'(irq), 1);
        do_ack(12'h2A2);
        chk("R7", "ext vec", 32'(vec), 32'h0A0);
        chk("R8", "ret_pc ext", 32'(ret_pc), 32'h2A2);
        // falling edge ignored under rising polarity
        wr_sts(8'h10);
        ext_pin = 0;
        ticks(4);
        chk("R4", "falling ignored", 32'(irq), 0);

        // R4: edges discarded while disabled
        wr_ctl(8'h04);
        ext_pin = 1;
        ticks(4);
        wr_ctl(8'h05);
        ticks(2);
        chk("R4", "disabled edge dropped", 32'(irq), 0);

        // R4: falling polarity
        wr_ctl(8'h01);
        ext_pin = 0;
        ticks(3);
        chk("R4", "falling edge", 32'(irq), 1);
        do_ack(12'h011);
        chk("R7", "falling vec", 32'(vec), 32'h0A0);

        // R5: cancel pending external
        wr_ctl(8'h05);
        ext_pin = 1;
        ticks(4);
        chk("R2", "held by master", 32'(irq), 0);
        wr_ctl(8'h04);
        wr_ctl(8'h05);
        wr_sts(8'h10);
        chk("R5", "cancelled stays gone", 32'(irq), 0);

        // R7 / R9: priority and loser kept
        wr_sts(8'h00);
        wr_ctl(8'h07);
        ext_pin = 0; ticks(3);
        ext_pin = 1;
        pulse_tmr();
        ticks(3);
        wr_sts(8'h10);
        chk("R2", "irq both pending", 32'(irq), 1);
        do_ack(12'h300);
        chk("R7", "timer wins", 32'(vec), 32'h020);
        chk("R9", "loser masked", 32'(irq), 0);
        wr_sts(8'h10);
        chk("R9", "loser raised", 32'(irq), 1);
        do_ack(12'h301);
        chk("R9", "loser vec", 32'(vec), 32'h0A0);
        chk("R8", "loser ret", 32'(ret_pc), 32'h301);

        // R6: stray acknowledge ignored
        do_ack(12'h777);
        chk("R6", "stray ack ret", 32'(ret_pc), 32'h301);
        chk("R6", "stray ack vec", 32'(vec), 32'h0A0);
        chk("R6", "stray ack ctl", 32'(ctl_q), 32'h07);

        // R10: new timer request in the acknowledge cycle
        wr_ctl(8'h02);
        wr_sts(8'h10);
        pulse_tmr();
        chk("R2", "timer raised", 32'(irq), 1);
        tmr_req = 1; ack = 1; pc_in = 12'h055; tick();
        tmr_req = 0; ack = 0;
        chk("R10", "ack taken", 32'(ret_pc), 32'h055);
        wr_sts(8'h10);
        chk("R10", "new request kept", 32'(irq), 1);
        do_ack(12'h056);

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 5) == 0) ext_pin = ~ext_pin;
            tmr_req = ($urandom_range(0, 15) == 0);
            ctl_we = ($urandom_range(0, 31) == 0);
            ctl_wdata = 8'($urandom_range(0, 255));
            sts_we = ($urandom_range(0, 15) == 0);
            sts_wdata = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'h10;
            ack = ($urandom_range(0, 3) == 0);
            pc_in = PC_W'($urandom_range(0, 4095));
            tick();
        end
        tmr_req = 0; ctl_we = 0; sts_we = 0; ack = 0;
        ticks(2);
        finish_run();
    end
endmodule